// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. It accepts one read or one write on every enabled clock, in any mix, with no idle turnaround cycle. The trick is a fixed write-data delay. Write data arrives on the shared bus in the same slot a read would use for its result, so the bus never has to change direction mid-flow. A small parameterised array stands in for the real depth. Each stored byte is 9 bits wide, eight data bits plus a parity bit.

A command is sampled on an enabled rising edge. The device is selected by three chip enables, and the command is a read or a write according to the write-enable pin. Read data comes out of an output register one enabled edge later. Write data is sampled from the bus at the second enabled edge after the command. At that edge it is committed through a per-byte mask.

A clock-enable pin freezes the whole pipeline. An advance control repeats the previous command type so that an external burst address generator can step through addresses. The output drivers are switched by pipeline state, and an asynchronous output-enable pin can mask them further. The bidirectional bus is modelled as separate input, output and output-enable ports.

Top module: `nbt_sram`

## Requirements
- R1: With `advance` low, a command is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on an enabled edge. Any other combination is a deselect. A deselect writes nothing and drives nothing.
- R2: A selected read with `we_n`=1, sampled at enabled edge k, drives `dq_oe` high (given `oe_n`=0) after enabled edge k+1. In that cycle `dq_out` holds the word at `addr`.
- R3: A selected write with `we_n`=0 at enabled edge k samples `dq_in` at enabled edge k+2. It stores the sampled word at the address captured at edge k.
- R4: `bw_n[i]`=0 enables byte i, which is `dq` bits [9i+8:9i] with the parity bit at position 9i+8. Bytes with `bw_n[i]`=1 keep their stored value.
- R5: While `cen_n`=1 a clock edge is ignored. The pipeline, the stored words, `dq_out` and the driver state all hold.
- R6: While `oe_n`=1, `dq_oe` is low whatever the pipeline state is.
- R7: `dq_oe` is low in the output slot of a write and in the output slot of a deselect. This holds even with `oe_n`=0.
- R8: Reads and writes may alternate on consecutive enabled edges with no dead cycle. Every read returns the most recent committed data.
- R9: A read issued on the enabled edge right after a write to the same address returns the new write data for the enabled bytes and the older stored bytes for the rest.
- R10: With `advance`=1, the chip enables and `we_n` are ignored. The selection and read/write type of the last command loaded with `advance`=0 are repeated, using the present `addr` and `bw_n`.
- R11: After reset `dq_oe` is low until a read reaches the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | NB | Per-byte write selects, active low |
| cen_n | input | 1 | Clock enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| advance | input | 1 | 1 = continue the previous command type, 0 = load a new command |
| dq_in | input | NB*9 | Bus value seen by the device |
| dq_out | output | NB*9 | Read data from the output register |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench first fills the array with back-to-back writes and reads the contents back. This separates a wrong read latency from a wrong write-data slot. Directed patterns then cover several cases:
- Masked writes distinguish byte lanes and parity positions.
- A read right after a write to the same address exposes a missing bypass.
- Deselect variants and advance sequences show whether the command decode or the repeat logic is at fault.
- Stall runs with `cen_n` high and `oe_n` toggles separate pipeline freezing from pin masking.

A long seeded random mix of reads, writes, deselects, stalls and advances is compared against a cycle model written from the requirements.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int unsigned BYTE_BITS = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } nbt_op_e;
endpackage

// File: rtl/nbt_rst_sync.sv
module nbt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/nbt_ctrl.sv
module nbt_ctrl
  import nbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NB     = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     bw_n,
  output logic              rd_go,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [NB-1:0]     wr_mask,
  output logic              drive_q
);
  logic              en;
  logic              sel_now, wr_now;
  nbt_op_e           cmd_op;

  nbt_op_e           s1_op_q, s1_op_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d;
  logic [NB-1:0]     s1_mask_q, s1_mask_d;
  logic              s2_vld_q, s2_vld_d;
  logic [ADDR_W-1:0] s2_addr_q, s2_addr_d;
  logic [NB-1:0]     s2_mask_q, s2_mask_d;
  logic              last_sel_q, last_sel_d;
  logic              last_we_q, last_we_d;
  logic              drive_d;

  assign en = ~cen_n;

  // command decode: advance repeats the last loaded selection and type
  always_comb begin
    sel_now = advance ? last_sel_q : (~ce1_n & ce2 & ~ce3_n);
    wr_now  = advance ? last_we_q  : ~we_n;
    if (!sel_now)    cmd_op = OP_IDLE;
    else if (wr_now) cmd_op = OP_WRITE;
    else             cmd_op = OP_READ;
  end

  // next-state
  always_comb begin
    s1_op_d    = s1_op_q;
    s1_addr_d  = s1_addr_q;
    s1_mask_d  = s1_mask_q;
    s2_vld_d   = s2_vld_q;
    s2_addr_d  = s2_addr_q;
    s2_mask_d  = s2_mask_q;
    last_sel_d = last_sel_q;
    last_we_d  = last_we_q;
    drive_d    = drive_q;
    if (en) begin
      s1_op_d   = cmd_op;
      s1_addr_d = addr;
      s1_mask_d = ~bw_n;
      s2_vld_d  = (s1_op_q == OP_WRITE);
      s2_addr_d = s1_addr_q;
      s2_mask_d = s1_mask_q;
      drive_d   = (s1_op_q == OP_READ);
      if (!advance) begin
        last_sel_d = ~ce1_n & ce2 & ~ce3_n;
        last_we_d  = ~we_n;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_q    <= OP_IDLE;
      s2_vld_q   <= 1'b0;
      last_sel_q <= 1'b0;
      last_we_q  <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      s1_op_q    <= s1_op_d;
      s2_vld_q   <= s2_vld_d;
      last_sel_q <= last_sel_d;
      last_we_q  <= last_we_d;
      drive_q    <= drive_d;
    end
  end

  // address and mask registers carry no reset
  always_ff @(posedge clk) begin
    s1_addr_q <= s1_addr_d;
    s1_mask_q <= s1_mask_d;
    s2_addr_q <= s2_addr_d;
    s2_mask_q <= s2_mask_d;
  end

  assign rd_go   = en & (s1_op_q == OP_READ);
  assign rd_addr = s1_addr_q;
  assign wr_go   = en & s2_vld_q;
  assign wr_addr = s2_addr_q;
  assign wr_mask = s2_mask_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    cen_n |=> ($stable(drive_q) && $stable(s2_vld_q) && $stable(s1_op_q))); // R5
  AST_WRITE_SLOT_DARK: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cen_n && s1_op_q == OP_WRITE) |=> !drive_q); // R7
  AST_IDLE_SLOT_DARK: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cen_n && s1_op_q == OP_IDLE) |=> !drive_q); // R7
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cen_n && s1_op_q == OP_READ) |=> drive_q); // R2
  AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cen_n && s1_op_q == OP_WRITE) |=> s2_vld_q); // R3
endmodule

// File: rtl/nbt_array.sv
module nbt_array
  import nbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NB     = 2
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      rd_go,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic                      wr_go,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [NB-1:0]             wr_mask,
  input  logic [NB*BYTE_BITS-1:0]   din,
  output logic [NB*BYTE_BITS-1:0]   dout_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned W     = NB * BYTE_BITS;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_word;
  logic [W-1:0] merged;
  logic         same_addr;

  assign rd_word   = mem[rd_addr];
  assign same_addr = wr_go & (wr_addr == rd_addr);

  // bypass: a write committing on this edge overrides its enabled bytes
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[b*BYTE_BITS +: BYTE_BITS] = (same_addr && wr_mask[b])
      ? din[b*BYTE_BITS +: BYTE_BITS]
      : rd_word[b*BYTE_BITS +: BYTE_BITS];
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_mask[b]) mem[wr_addr][b*BYTE_BITS +: BYTE_BITS] <= din[b*BYTE_BITS +: BYTE_BITS];
      end
    end
    if (rd_go) dout_q <= merged;
  end

  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_go |=> $stable(dout_q)); // R5
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NB     = 2,
  localparam int unsigned W     = NB * BYTE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic [NB-1:0]     bw_n,
  input  logic              cen_n,
  input  logic              oe_n,
  input  logic              advance,
  input  logic [W-1:0]      dq_in,
  output logic [W-1:0]      dq_out,
  output logic              dq_oe
);
  logic              rst_ni;
  logic              rd_go, wr_go, drive_q;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [NB-1:0]     wr_mask;

  nbt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  nbt_ctrl #(.ADDR_W(ADDR_W), .NB(NB)) u_ctrl (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .cen_n   (cen_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .we_n    (we_n),
    .advance (advance),
    .addr    (addr),
    .bw_n    (bw_n),
    .rd_go   (rd_go),
    .rd_addr (rd_addr),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask),
    .drive_q (drive_q)
  );

  nbt_array #(.ADDR_W(ADDR_W), .NB(NB)) u_array (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .rd_go   (rd_go),
    .rd_addr (rd_addr),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask),
    .din     (dq_in),
    .dout_q  (dq_out)
  );

  // the asynchronous pin can only narrow what the pipeline allows
  assign dq_oe = drive_q & ~oe_n;

  AST_NO_DRIVE_IN_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_go |-> !dq_oe); // R7
endmodule

// File: tb/nbt_sram_test.sv
`timescale 1ns/1ps
module nbt_sram_test;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int W  = NB * 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce1_n, ce2, ce3_n, we_n, cen_n, oe_n, advance;
  logic [NB-1:0] bw_n;
  logic [W-1:0]  dq_in, dq_out;
  logic          dq_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  logic [W-1:0]  m_mem [16];
  int            m_s1_op = 0;
  logic [AW-1:0] m_s1_addr = '0;
  logic [NB-1:0] m_s1_mask = '0;
  bit            m_s2_vld = 0;
  logic [AW-1:0] m_s2_addr = '0;
  logic [NB-1:0] m_s2_mask = '0;
  bit            m_drive = 0;
  logic [W-1:0]  m_dout = '0;
  bit            m_last_sel = 0, m_last_we = 0;

  nbt_sram #(.ADDR_W(AW), .NB(NB)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .we_n(we_n), .bw_n(bw_n), .cen_n(cen_n), .oe_n(oe_n), .advance(advance),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #2 clk = ~clk;

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [NB-1:0] m);
    logic [W-1:0] r = old;
    for (int b = 0; b < NB; b++) if (m[b]) r[b*9 +: 9] = nw[b*9 +: 9];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // kind: 0 deselect, 1 read, 2 write
  task automatic drv(int kind, int a, logic [NB-1:0] m, bit adv, bit cen, bit oe);
    int v = $urandom % 3;
    addr = a[AW-1:0];
    bw_n = ~m;
    advance = adv;
    cen_n = cen;
    oe_n = oe;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    we_n = (kind == 2) ? 1'b0 : 1'b1;
    if (kind == 0) begin
      we_n = $urandom % 2;
      if (v == 0) ce1_n = 1'b1;
      else if (v == 1) ce2 = 1'b0;
      else ce3_n = 1'b1;
    end
  endtask

  task automatic model_step();
    bit sel, w;
    if (cen_n) return;
    if (m_s2_vld) m_mem[m_s2_addr] = merge(m_mem[m_s2_addr], dq_in, m_s2_mask);
    m_drive = (m_s1_op == 1);
    if (m_drive) m_dout = m_mem[m_s1_addr];
    m_s2_vld = (m_s1_op == 2);
    m_s2_addr = m_s1_addr;
    m_s2_mask = m_s1_mask;
    sel = advance ? m_last_sel : (!ce1_n && ce2 && !ce3_n);
    w   = advance ? m_last_we  : !we_n;
    if (!advance) begin
      m_last_sel = !ce1_n && ce2 && !ce3_n;
      m_last_we  = !we_n;
    end
    m_s1_op = sel ? (w ? 2 : 1) : 0;
    m_s1_addr = addr;
    m_s1_mask = ~bw_n;
  endtask

  // one clock: model at the edge, compare at the following falling edge
  task automatic cyc(string req);
    logic [W-1:0] e;
    dq_in = W'($urandom);
    @(posedge clk);
    model_step();
    @(negedge clk);
    e = {W{1'b0}};
    e[0] = m_drive && !oe_n;
    check(req, {{(W-1){1'b0}}, dq_oe}, e);
    if (m_drive && !oe_n) check(req, dq_out, m_dout);
  endtask

  task automatic op(string req, int kind, int a, logic [NB-1:0] m);
    drv(kind, a, m, 0, 0, 0);
    cyc(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    drv(0, 0, '0, 0, 0, 0);
    dq_in = '0;
    repeat (3) @(negedge clk);
    check("R11", {{(W-1){1'b0}}, dq_oe}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) op("R11", 0, 0, 0);

    // fill back-to-back, then read back (R3, R2)
    for (int i = 0; i < 16; i++) op("R3", 2, i, 2'b11);
    op("R3", 0, 0, 0); op("R3", 0, 0, 0);
    for (int i = 0; i < 16; i++) op("R2", 1, i, 0);
    op("R2", 0, 0, 0);

    // byte lanes and parity bits (R4)
    op("R4", 2, 3, 2'b01); op("R4", 0, 0, 0); op("R4", 0, 0, 0);
    op("R4", 2, 3, 2'b10); op("R4", 0, 0, 0); op("R4", 0, 0, 0);
    op("R4", 2, 3, 2'b00); op("R4", 0, 0, 0); op("R4", 0, 0, 0);
    op("R4", 1, 3, 0); op("R4", 0, 0, 0);

    // read right after write to the same address (R9)
    op("R9", 2, 5, 2'b10); op("R9", 1, 5, 0); op("R9", 0, 0, 0);
    op("R9", 2, 6, 2'b01); op("R9", 1, 6, 0); op("R9", 1, 6, 0); op("R9", 0, 0, 0);

    // write slot and deselect slot stay dark (R7), deselect writes nothing (R1)
    op("R7", 1, 1, 0); op("R7", 2, 1, 2'b11); op("R7", 0, 0, 0); op("R7", 0, 0, 0);
    for (int v = 0; v < 6; v++) op("R1", 0, 7, 2'b11);
    op("R1", 0, 0, 0); op("R1", 1, 7, 0); op("R1", 0, 0, 0);

    // alternate every cycle (R8)
    for (int i = 0; i < 24; i++) op("R8", (i % 2) ? 1 : 2, i % 4, 2'b11);
    op("R8", 0, 0, 0); op("R8", 0, 0, 0);

    // stalls (R5)
    op("R5", 1, 2, 0);
    for (int i = 0; i < 4; i++) begin drv(2, 9, 2'b11, 0, 1, 0); cyc("R5"); end
    op("R5", 2, 8, 2'b11);
    for (int i = 0; i < 3; i++) begin drv(1, 8, 0, 0, 1, 0); cyc("R5"); end
    op("R5", 1, 8, 0);
    for (int i = 0; i < 3; i++) begin drv(0, 0, 0, 0, 1, 0); cyc("R5"); end
    op("R5", 1, 9, 0); op("R5", 0, 0, 0);

    // output-enable pin masks (R6)
    op("R6", 1, 4, 0);
    drv(0, 0, 0, 0, 0, 1); cyc("R6");
    drv(1, 4, 0, 0, 0, 1); cyc("R6");
    drv(0, 0, 0, 0, 0, 0); cyc("R6");

    // advance repeats the loaded command (R10)
    op("R10", 1, 10, 0);
    for (int i = 11; i < 14; i++) begin drv(0, i, 0, 1, 0, 0); we_n = 1'b0; cyc("R10"); end
    op("R10", 2, 12, 2'b11);
    for (int i = 13; i < 15; i++) begin drv(1, i, 2'b01, 1, 0, 0); cyc("R10"); end
    op("R10", 0, 0, 0);
    for (int i = 0; i < 3; i++) begin drv(2, 14, 2'b11, 1, 0, 0); cyc("R10"); end
    op("R10", 0, 0, 0);
    for (int i = 12; i < 16; i++) op("R10", 1, i, 0);
    op("R10", 0, 0, 0);

    // seeded random mix (R8)
    for (int i = 0; i < 3000; i++) begin
      drv($urandom % 3, $urandom % 16, NB'($urandom), ($urandom % 5) == 0,
          ($urandom % 7) == 0, ($urandom % 10) == 0);
      cyc("R8");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule